// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block sits between the read path of a byte-wide flash array and the sequencer that runs program and erase operations. The sequencer tells it when an operation starts, which kind it is, when the erase acceptance window closes, when the operation ends, and when it has overrun its time limit. While an operation is in flight, every read returns a status word instead of array contents. That word carries a polling bit, a toggle bit, an error bit and an erase-timer bit. Once the operation has ended, reads go back to returning the array byte unchanged.

The read side uses a synchronous strobe, `rd_stb`, in place of the enable edges of an asynchronous bus. A read takes effect on the clock edge where the strobe is first seen high. `rd_data` is a combinational view of the current state and of `arr_rdata`. The read port has no back-pressure: the block always accepts a read, and `rd_data` is valid whenever it is sampled. All sequencer inputs are single-cycle pulses. `cmd_reset` (the reset instruction) takes priority over every other pulse.

Top module: `flash_status_reporter`

## Requirements
- R1: After `rst_n` is deasserted, the block is idle and `rd_data` equals `arr_rdata`. The internal toggle level starts at 0, so the first status read of the first operation shows bit 6 = 1.
- R2: While no operation is active, `rd_data` equals `arr_rdata` for every byte value.
- R3: After `start_prog`, status bit 7 reads the inverse of `prog_msb`, and bits 5 and 3 read 0. After `op_done`, `rd_data` equals `arr_rdata` again.
- R4: After `start_erase`, bit 7 reads 0 and bit 3 reads 0 while the acceptance window is open. After `erase_go`, bit 3 reads 1. After `op_done`, `rd_data` equals `arr_rdata`.
- R5: While an operation runs and is not suspended, bit 6 inverts on each clock edge where `rd_stb` rises. It keeps its value when the strobe is held or low.
- R6: While an erase is suspended (`susp_req` pulse during erasing), bit 6 stays constant across reads and `op_done` is ignored. `resume` re-enables toggling.
- R7: `op_fail` during programming or erasing sets bit 5. The block then stays busy and ignores `op_done` until `cmd_reset`, which clears bit 5 and returns the block to array reads.
- R8: The status word has bits 4, 2, 1 and 0 at 0. Its layout is {bit7 poll, bit6 toggle, bit5 error, bit4 0, bit3 erase-timer, bits 2..0 0}.
- R9: A start with `all_prot` high gives a status of bit 7 = 0, bit 3 = 0, with toggling. This status lasts exactly PROT_CYCLES clock edges after the start edge, and then array reads resume.
- R10: Start pulses that arrive while an operation is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_prog | input | 1 | Pulse: byte program begins |
| start_erase | input | 1 | Pulse: erase begins (acceptance window opens) |
| all_prot | input | 1 | Qualifies a start: every selected block is protected |
| prog_msb | input | 1 | Bit 7 of the byte being programmed, sampled at start |
| erase_go | input | 1 | Pulse: acceptance window expired, erasing begins |
| op_done | input | 1 | Pulse: operation completed |
| op_fail | input | 1 | Pulse: operation exceeded its time limit |
| susp_req | input | 1 | Pulse: erase suspend acknowledged |
| resume | input | 1 | Pulse: erase resumed |
| cmd_reset | input | 1 | Pulse: reset instruction |
| rd_stb | input | 1 | Read strobe |
| arr_rdata | input | DATA_W | Array byte at the current read address |
| rd_data | output | DATA_W | Read data: status word or array byte |

## Verification
Each sequencer pulse changes the state on the edge where it is sampled. Because `rd_data` is combinational, the new status can be seen in the same cycle after that edge. The bench drives every input one time unit after a rising edge and samples one time unit after the next. The toggle bit changes on the edge where a strobe rise is seen, so each read is checked both just after that edge and one cycle later with the strobe low, which confirms that the toggle does not flip again. The protected-block interval is checked at edge PROT_CYCLES-1, where it must still be busy, and at edge PROT_CYCLES, where it must have returned to array data.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    MD_IDLE = 3'd0,
    MD_PROG = 3'd1,
    MD_EWIN = 3'd2,
    MD_ERUN = 3'd3,
    MD_PROT = 3'd4
  } fsr_mode_e;

  localparam int BIT_POLL  = 7;
  localparam int BIT_TOG   = 6;
  localparam int BIT_ERR   = 5;
  localparam int BIT_ETIME = 3;
endpackage

// File: rtl/fsr_op_track.sv
module fsr_op_track
  import fsr_pkg::*;
#(
  parameter int PROT_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_prog,
  input  logic      start_erase,
  input  logic      all_prot,
  input  logic      prog_msb,
  input  logic      erase_go,
  input  logic      op_done,
  input  logic      op_fail,
  input  logic      susp_req,
  input  logic      resume,
  input  logic      cmd_reset,
  output fsr_mode_e mode,
  output logic      err,
  output logic      susp,
  output logic      poll_bit
);
  localparam int CNT_W = $clog2(PROT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROT_CYCLES - 1);

  logic [CNT_W-1:0] prot_cnt;
  logic             any_start;

  assign any_start = start_prog | start_erase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MD_IDLE;
      err      <= 1'b0;
      susp     <= 1'b0;
      poll_bit <= 1'b0;
      prot_cnt <= '0;
    end else if (cmd_reset) begin
      mode     <= MD_IDLE;
      err      <= 1'b0;
      susp     <= 1'b0;
      prot_cnt <= '0;
    end else begin
      case (mode)
        MD_IDLE: begin
          if (any_start) begin
            prot_cnt <= '0;
            if (all_prot) begin
              mode     <= MD_PROT;
              poll_bit <= 1'b0;
            end else if (start_prog) begin
              mode     <= MD_PROG;
              poll_bit <= ~prog_msb;
            end else begin
              mode     <= MD_EWIN;
              poll_bit <= 1'b0;
            end
          end
        end
        MD_PROG: begin
          if (op_fail)             err  <= 1'b1;
          else if (op_done && !err) mode <= MD_IDLE;
        end
        MD_EWIN: begin
          if (erase_go) mode <= MD_ERUN;
        end
        MD_ERUN: begin
          if (op_fail)                     err  <= 1'b1;
          else if (susp_req && !err)       susp <= 1'b1;
          else if (resume)                 susp <= 1'b0;
          else if (op_done && !err && !susp) mode <= MD_IDLE;
        end
        MD_PROT: begin
          if (prot_cnt == CNT_LAST) mode     <= MD_IDLE;
          else                      prot_cnt <= prot_cnt + 1'b1;
        end
        default: mode <= MD_IDLE;
      endcase
    end
  end

  // R7: the error flag survives everything except the reset instruction
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !cmd_reset) |=> err);

  // R7: a failed operation keeps the block busy
  p_fail_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && mode != MD_IDLE && !cmd_reset) |=> (mode != MD_IDLE));

  // R10: the polling value latched at start is not disturbed by later starts
  p_busy_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_IDLE) |=> $stable(poll_bit));

  // R9: the protected interval counter stays inside its window
  p_prot_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PROT) |-> (prot_cnt <= CNT_LAST));

  // R6: suspension only exists while erasing
  p_susp_erun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> (mode == MD_ERUN));
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic run,
  output logic tog
);
  logic stb_q;
  logic stb_rise;

  assign stb_rise = rd_stb & ~stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      tog   <= 1'b0;
    end else begin
      stb_q <= rd_stb;
      if (stb_rise && run) tog <= ~tog;
    end
  end

  // R5: no strobe rise while running means no change
  p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_rise && run) |=> $stable(tog));

  // R5: each counted read inverts the level
  p_tog_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && run) |=> (tog != $past(tog)));
endmodule

// File: rtl/fsr_word_mux.sv
module fsr_word_mux
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  fsr_mode_e         mode,
  input  logic              err,
  input  logic              tog,
  input  logic              poll_bit,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] stat_word;

  assign busy = (mode != MD_IDLE);

  always_comb begin
    stat_word            = '0;
    stat_word[BIT_POLL]  = poll_bit;
    stat_word[BIT_TOG]   = tog;
    stat_word[BIT_ERR]   = err;
    stat_word[BIT_ETIME] = (mode == MD_ERUN);
    rd_data              = busy ? stat_word : arr_rdata;
  end
endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
  import fsr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PROT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              all_prot,
  input  logic              prog_msb,
  input  logic              erase_go,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              susp_req,
  input  logic              resume,
  input  logic              cmd_reset,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data
);
  fsr_mode_e mode;
  logic      err;
  logic      susp;
  logic      poll_bit;
  logic      tog;
  logic      busy;

  fsr_op_track #(.PROT_CYCLES(PROT_CYCLES)) track_i (
    .clk(clk), .rst_n(rst_n),
    .start_prog(start_prog), .start_erase(start_erase),
    .all_prot(all_prot), .prog_msb(prog_msb),
    .erase_go(erase_go), .op_done(op_done), .op_fail(op_fail),
    .susp_req(susp_req), .resume(resume), .cmd_reset(cmd_reset),
    .mode(mode), .err(err), .susp(susp), .poll_bit(poll_bit)
  );

  fsr_toggle tog_i (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
    .run(busy && !susp), .tog(tog)
  );

  fsr_word_mux #(.DATA_W(DATA_W)) mux_i (
    .mode(mode), .err(err), .tog(tog), .poll_bit(poll_bit),
    .arr_rdata(arr_rdata), .busy(busy), .rd_data(rd_data)
  );

  // R8: reserved status positions read zero during an operation
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000));

  // R2: an idle block passes array data through
  p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_data == arr_rdata));
endmodule

// File: tb/flash_status_reporter_tb_top.sv
module flash_status_reporter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROT_N     = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_prog = 0, start_erase = 0, all_prot = 0, prog_msb = 0;
  logic       erase_go = 0, op_done = 0, op_fail = 0, susp_req = 0;
  logic       resume = 0, cmd_reset = 0, rd_stb = 0;
  logic [7:0] arr_rdata = 8'h5A;
  logic [7:0] rd_data;

  int  n_tests = 0;
  int  n_fail  = 0;
  logic exp_tog = 1'b0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_reporter #(.DATA_W(8), .PROT_CYCLES(PROT_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .all_prot(all_prot), .prog_msb(prog_msb), .erase_go(erase_go),
    .op_done(op_done), .op_fail(op_fail), .susp_req(susp_req),
    .resume(resume), .cmd_reset(cmd_reset), .rd_stb(rd_stb),
    .arr_rdata(arr_rdata), .rd_data(rd_data)
  );

  function automatic logic [7:0] sw(logic b7, logic t, logic e, logic b3);
    return {b7, t, e, 1'b0, b3, 3'b000};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // one read: strobe rises, checked after the edge, then strobe low one cycle
  task automatic rd(string req, logic b7, logic e, logic b3, bit runs);
    rd_stb = 1'b1;
    tick();
    if (runs) exp_tog = ~exp_tog;
    chk(req, rd_data, sw(b7, exp_tog, e, b3));
    rd_stb = 1'b0;
    tick();
    chk({req, "/R5 hold"}, rd_data, sw(b7, exp_tog, e, b3));
  endtask

  task automatic pulse_done();
    op_done = 1'b1; tick(); op_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state passes array through
    chk("R1 reset", rd_data, 8'h5A);

    // R2: idle passthrough sweep
    for (int v = 0; v < 256; v++) begin
      arr_rdata = 8'(v); #1;
      chk("R2 idle", rd_data, 8'(v));
    end

    // R1/R3: first program read shows toggle 1; sweep all bytes
    for (int b = 0; b < 256; b++) begin
      logic [7:0] by;
      by = 8'(b);
      arr_rdata = ~by;
      prog_msb = by[7]; start_prog = 1'b1; tick(); start_prog = 1'b0;
      chk("R3 busy", rd_data, sw(~by[7], exp_tog, 1'b0, 1'b0));
      rd(b == 0 ? "R1 first toggle" : "R3 read", ~by[7], 1'b0, 1'b0, 1);
      pulse_done();
      arr_rdata = by; #1;
      chk("R3 done", rd_data, by);
    end

    // R10: starts while busy are ignored
    arr_rdata = 8'h33;
    prog_msb = 1'b0; start_prog = 1'b1; tick(); start_prog = 1'b0;
    start_erase = 1'b1; all_prot = 1'b1; prog_msb = 1'b1; tick();
    start_erase = 1'b0; all_prot = 1'b0;
    start_prog = 1'b1; tick(); start_prog = 1'b0;
    rd("R10", 1'b1, 1'b0, 1'b0, 1);
    pulse_done();
    chk("R10 done", rd_data, 8'h33);

    // R4: erase window then erasing
    arr_rdata = 8'hFF;
    start_erase = 1'b1; tick(); start_erase = 1'b0;
    rd("R4 window", 1'b0, 1'b0, 1'b0, 1);
    pulse_done();
    chk("R4 done ignored in window", rd_data, sw(1'b0, exp_tog, 1'b0, 1'b0));
    erase_go = 1'b1; tick(); erase_go = 1'b0;
    rd("R4 erasing", 1'b0, 1'b0, 1'b1, 1);
    // R6: suspend freezes toggle and blocks completion
    susp_req = 1'b1; tick(); susp_req = 1'b0;
    rd("R6 suspended", 1'b0, 1'b0, 1'b1, 0);
    rd("R6 suspended again", 1'b0, 1'b0, 1'b1, 0);
    pulse_done();
    chk("R6 done ignored", rd_data, sw(1'b0, exp_tog, 1'b0, 1'b1));
    resume = 1'b1; tick(); resume = 1'b0;
    rd("R6 resumed", 1'b0, 1'b0, 1'b1, 1);
    pulse_done();
    chk("R4 erase done", rd_data, 8'hFF);

    // R7: failure in program
    arr_rdata = 8'h81;
    prog_msb = 1'b1; start_prog = 1'b1; tick(); start_prog = 1'b0;
    op_fail = 1'b1; tick(); op_fail = 1'b0;
    rd("R7 error bit", 1'b0, 1'b1, 1'b0, 1);
    pulse_done();
    chk("R7 done ignored", rd_data, sw(1'b0, exp_tog, 1'b1, 1'b0));
    cmd_reset = 1'b1; tick(); cmd_reset = 1'b0;
    chk("R7 reset clears", rd_data, 8'h81);
    // R7: failure in erase
    start_erase = 1'b1; tick(); start_erase = 1'b0;
    erase_go = 1'b1; tick(); erase_go = 1'b0;
    op_fail = 1'b1; tick(); op_fail = 1'b0;
    rd("R7 erase error", 1'b0, 1'b1, 1'b1, 1);
    cmd_reset = 1'b1; tick(); cmd_reset = 1'b0;
    chk("R7 erase reset", rd_data, 8'h81);
    // R8: reserved bits already compared in every full-byte status check
    prog_msb = 1'b0; start_prog = 1'b1; tick(); start_prog = 1'b0;
    chk("R8 reserved", rd_data & 8'h17, 8'h00);
    pulse_done();

    // R9: protected interval
    arr_rdata = 8'hC3;
    all_prot = 1'b1; start_prog = 1'b1; prog_msb = 1'b0; tick();
    all_prot = 1'b0; start_prog = 1'b0;
    for (int k = 1; k <= PROT_N; k++) begin
      rd_stb = (k == 1);
      tick();
      if (k == 1) exp_tog = ~exp_tog;
      if (k == 1) chk("R9 toggles", rd_data, sw(1'b0, exp_tog, 1'b0, 1'b0));
      if (k == PROT_N - 1) chk("R9 still busy", rd_data, sw(1'b0, exp_tog, 1'b0, 1'b0));
      if (k == PROT_N) chk("R9 returns", rd_data, 8'hC3);
    end
    rd_stb = 1'b0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule